// File: doc/BRIEF.md
# Watchdog Timer with Safe-Frequency Fallback

This block guards the frequency-select setting of a clock generator. A small register file holds two registers: the active frequency-select code that drives the generator, and a watchdog control register. The control register holds a run bit, a safe-fallback enable, a read-only expiry flag and a 5-bit safe frequency code. Software arms the watchdog by writing the run bit as 1, or by pulsing the restart strobe. While armed, the counter steps down once per prescaled tick pulse.

When the count reaches zero, the watchdog does not reset anything. It drops its run bit, sets the sticky expiry flag and, if the safe-fallback enable is set, copies the safe code into the frequency-select register once. A system left at an unworkable frequency therefore returns by itself to a known-good setting.

Top module: `wdt_freq_guard`

## Requirements
- R1: After reset the control register reads C0h and the frequency-select register reads the parameter FREQ_RST (default 03h). Control layout: bit 7 run, bit 6 safe-fallback enable, bit 5 expiry flag, bits 4:0 safe code. The frequency register reads as {3'b000, code}.
- R2: While running, the counter decrements only in cycles where `tick` is 1. Expiry happens on the (2^CNT_W − 1)-th tick after a restart, which is the 15th tick by default.
- R3: On expiry the run bit reads 0 and the expiry flag reads 1.
- R4: A control write with bit 7 = 1, or a `kick` pulse, reloads the counter to full, sets run and clears the expiry flag in that same cycle. A restart takes priority over a tick and over a stop.
- R5: A control write with bit 7 = 0 (and no `kick`) stops the watchdog. Later ticks then cause no expiry, and the expiry flag keeps its value.
- R6: On expiry with the safe-fallback enable at 1, the safe code is loaded into the frequency-select register and appears on `freq_sel` at the same clock edge as the flag.
- R7: On expiry with the safe-fallback enable at 0, the frequency-select register is left unchanged.
- R8: The reload happens once per expiry. A later host write to the frequency register stays in place however many ticks follow.
- R9: A host write to the frequency register in the same cycle as an expiry reload loses to the reload.
- R10: `rd_data` is registered. It shows the register chosen by `rd_addr` (0 = frequency, 1 = control) as it stood before the clock edge that samples the address. The expiry flag bit ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Prescaled count-enable pulse |
| kick | input | 1 | Restart strobe |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 1 | Write address: 0 frequency, 1 control |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | Read address: 0 frequency, 1 control |
| rd_data | output | 8 | Registered read data |
| freq_sel | output | 5 | Active frequency-select code |

## Verification
The assertions check the local rules of the counter on every cycle. A restart lands a full count with the flag clear, an expiry leaves the flag set and the counter stopped, and a stop halts counting. The counter holds when it sees no tick, and a running counter is never zero. A reload always carries the safe code and the frequency register never moves without a cause. Whether an expiry reloads exactly once, and whether the whole tick count adds up to one expiry, can only be seen over the bench's long sequences. The same holds for the interplay of host writes with timeouts and the register read-back across random traffic.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int DATA_W  = 8;
  localparam int FREQ_W  = 5;
  localparam logic ADDR_FREQ = 1'b0;
  localparam logic ADDR_CTRL = 1'b1;
  localparam int BIT_RUN  = 7;
  localparam int BIT_SAFE = 6;
  localparam int BIT_FLAG = 5;

  typedef struct packed {
    logic              run;
    logic              safe_en;
    logic              flag;
    logic [FREQ_W-1:0] code;
  } wdg_ctrl_t;
endpackage

// File: rtl/wdg_countdown.sv
module wdg_countdown #(
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic restart,
  input  logic stop,
  output logic run,
  output logic flag,
  output logic expire
);
  localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt;

  assign expire = tick && run && !restart && !stop && (cnt == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= FULL;
      run  <= 1'b1;
      flag <= 1'b0;
    end else if (restart) begin
      cnt  <= FULL;
      run  <= 1'b1;
      flag <= 1'b0;
    end else if (stop) begin
      run  <= 1'b0;
    end else if (tick && run) begin
      cnt <= cnt - ONE;
      if (cnt == ONE) begin
        run  <= 1'b0;
        flag <= 1'b1;
      end
    end
  end

  // R4
  restart_reload_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> (run && !flag && cnt == FULL));
  // R3
  expire_flag_chk: assert property (@(posedge clk) disable iff (rst)
    expire |=> (!run && flag && cnt == '0));
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !restart) |=> $stable(cnt));
  // R5
  stop_halt_chk: assert property (@(posedge clk) disable iff (rst)
    (stop && !restart) |=> !run);
  // R2
  run_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt != '0));
endmodule

// File: rtl/wdg_freq_reg.sv
module wdg_freq_reg #(
  parameter int               W   = 5,
  parameter logic [W-1:0]     RST = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         reload,
  input  logic [W-1:0] reload_code,
  input  logic         wr,
  input  logic [W-1:0] wr_code,
  output logic [W-1:0] freq
);
  always_ff @(posedge clk) begin
    if (rst)         freq <= RST;
    else if (reload) freq <= reload_code;
    else if (wr)     freq <= wr_code;
  end

  // R6 R9
  reload_wins_chk: assert property (@(posedge clk) disable iff (rst)
    reload |=> (freq == $past(reload_code)));
  // R7
  freq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!reload && !wr) |=> $stable(freq));
endmodule

// File: rtl/wdt_freq_guard.sv
module wdt_freq_guard #(
  parameter int          CNT_W    = 4,
  parameter logic [4:0]  FREQ_RST = 5'h03
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       kick,
  input  logic       wr_en,
  input  logic       wr_addr,
  input  logic [7:0] wr_data,
  input  logic       rd_addr,
  output logic [7:0] rd_data,
  output logic [4:0] freq_sel
);
  import wdg_pkg::*;

  logic              wr_ctrl, wr_freq;
  logic              restart, stop;
  logic              run, flag, expire;
  logic              safe_en;
  logic [FREQ_W-1:0] safe_code;
  wdg_ctrl_t         ctrl_view;

  assign wr_ctrl = wr_en && (wr_addr == ADDR_CTRL);
  assign wr_freq = wr_en && (wr_addr == ADDR_FREQ);
  assign restart = kick || (wr_ctrl && wr_data[BIT_RUN]);
  assign stop    = wr_ctrl && !wr_data[BIT_RUN];

  always_ff @(posedge clk) begin
    if (rst) begin
      safe_en   <= 1'b1;
      safe_code <= '0;
    end else if (wr_ctrl) begin
      safe_en   <= wr_data[BIT_SAFE];
      safe_code <= wr_data[FREQ_W-1:0];
    end
  end

  wdg_countdown #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .tick(tick), .restart(restart), .stop(stop),
    .run(run), .flag(flag), .expire(expire)
  );

  wdg_freq_reg #(.W(FREQ_W), .RST(FREQ_RST)) u_freq (
    .clk(clk), .rst(rst),
    .reload(expire && safe_en), .reload_code(safe_code),
    .wr(wr_freq), .wr_code(wr_data[FREQ_W-1:0]),
    .freq(freq_sel)
  );

  always_comb begin
    ctrl_view.run     = run;
    ctrl_view.safe_en = safe_en;
    ctrl_view.flag    = flag;
    ctrl_view.code    = safe_code;
  end

  always_ff @(posedge clk) begin
    if (rst)                       rd_data <= '0;
    else if (rd_addr == ADDR_CTRL) rd_data <= ctrl_view;
    else                           rd_data <= {{(DATA_W-FREQ_W){1'b0}}, freq_sel};
  end

  // R7
  no_fallback_chk: assert property (@(posedge clk) disable iff (rst)
    (expire && !safe_en && !wr_freq) |=> $stable(freq_sel));
  // R8
  single_expire_chk: assert property (@(posedge clk) disable iff (rst)
    expire |=> !expire);
endmodule

// File: tb/wdt_freq_guard_bench.sv
module wdt_freq_guard_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0, kick = 1'b0, wr_en = 1'b0, wr_addr = 1'b0, rd_addr = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [4:0] freq_sel;

  int checks = 0, fails = 0;
  bit finished = 0;

  // bench model state
  bit       m_run, m_safe, m_flag;
  logic [4:0] m_code, m_freq;
  int       m_cnt;
  localparam int FULL = 15;

  always #10 clk = ~clk;

  wdt_freq_guard u_wdt_freq_guard (
    .clk(clk), .rst(rst), .tick(tick), .kick(kick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .freq_sel(freq_sel)
  );

  function automatic logic [7:0] ctrl_exp();
    return {m_run, m_safe, m_flag, m_code};
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_run = 1; m_safe = 1; m_flag = 0; m_code = 0; m_freq = 5'h03; m_cnt = FULL;
  endtask

  task automatic model_step(input bit tk, kk, we, wa, input logic [7:0] wd);
    bit wctrl, wfreq, restart, stop, expire;
    wctrl = we && wa;
    wfreq = we && !wa;
    restart = kk || (wctrl && wd[7]);
    stop = wctrl && !wd[7];
    expire = 0;
    if (restart) begin
      m_cnt = FULL; m_run = 1; m_flag = 0;
    end else if (stop) begin
      m_run = 0;
    end else if (tk && m_run) begin
      m_cnt--;
      if (m_cnt == 0) begin
        m_run = 0; m_flag = 1; expire = 1;
      end
    end
    if (expire && m_safe) m_freq = m_code;
    else if (wfreq)       m_freq = wd[4:0];
    if (wctrl) begin
      m_safe = wd[6]; m_code = wd[4:0];
    end
  endtask

  task automatic cyc(input bit tk, kk, we, wa, input logic [7:0] wd, input bit ra, input string tag);
    logic [7:0] exp_rd;
    @(negedge clk);
    tick = tk; kick = kk; wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
    exp_rd = ra ? ctrl_exp() : {3'b000, m_freq};
    model_step(tk, kk, we, wa, wd);
    @(posedge clk); #1;
    chk(rd_data, exp_rd, {tag, " R10 read"});
    chk({3'b000, freq_sel}, {3'b000, m_freq}, {tag, " freq"});
  endtask

  task automatic ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1, 0, 0, 0, 8'h00, 1, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;

    // R1: reset values
    cyc(0, 0, 0, 0, 8'h00, 1, "R1");
    cyc(0, 0, 0, 0, 8'h00, 0, "R1");
    chk(rd_data, 8'h03, "R1 freq reset");
    cyc(0, 0, 0, 0, 8'h00, 1, "R1");
    chk(rd_data, 8'hC0, "R1 ctrl reset");

    // R4 R10: restart with safe code 15h; bit5 written 1 must be ignored
    cyc(0, 0, 1, 1, 8'hF5, 1, "R4");
    cyc(0, 0, 0, 0, 8'h00, 1, "R10");
    chk(rd_data, 8'hD5, "R10 flag read-only");
    // R2: 14 ticks do not expire, gaps between ticks do not count
    for (int i = 0; i < 14; i++) begin
      cyc(1, 0, 0, 0, 8'h00, 1, "R2");
      cyc(0, 0, 0, 0, 8'h00, 1, "R2");
    end
    chk(rd_data, 8'hD5, "R2 still running");
    // R3 R6: 15th tick expires and reloads
    cyc(1, 0, 0, 0, 8'h00, 1, "R6");
    chk({3'b0, freq_sel}, 8'h15, "R6 safe reload");
    cyc(0, 0, 0, 0, 8'h00, 1, "R3");
    chk(rd_data, 8'h75, "R3 expired status");

    // R8: host write after expiry stays
    cyc(0, 0, 1, 0, 8'h07, 1, "R8");
    ticks(25, "R8");
    chk({3'b0, freq_sel}, 8'h07, "R8 no second reload");

    // R4: kick restarts and clears flag
    cyc(0, 1, 0, 0, 8'h00, 1, "R4");
    cyc(0, 0, 0, 0, 8'h00, 1, "R4");
    chk(rd_data, 8'hD5, "R4 kick restart");

    // R7: fallback disabled
    cyc(0, 0, 1, 1, 8'h8A, 1, "R7");
    ticks(15, "R7");
    chk({3'b0, freq_sel}, 8'h07, "R7 freq unchanged");
    cyc(0, 0, 0, 0, 8'h00, 1, "R7");
    chk(rd_data, 8'h2A, "R7 flag set");

    // R5: stop keeps flag and prevents expiry
    cyc(0, 0, 1, 1, 8'h41, 1, "R5");
    ticks(30, "R5");
    chk({3'b0, freq_sel}, 8'h07, "R5 no reload when stopped");
    cyc(0, 0, 0, 0, 8'h00, 1, "R5");
    chk(rd_data, 8'h61, "R5 stopped, flag kept");

    // R4: restart beats stop and tick in same cycle
    cyc(1, 1, 1, 1, 8'h49, 1, "R4");
    ticks(14, "R4");
    cyc(0, 0, 0, 0, 8'h00, 1, "R4");
    chk(rd_data, 8'hC9, "R4 restart priority");

    // R9: host freq write collides with reload
    cyc(1, 0, 1, 0, 8'h1F, 1, "R9");
    chk({3'b0, freq_sel}, 8'h09, "R9 reload wins");

    // R2: random traffic
    for (int i = 0; i < 3000; i++) begin
      bit tk, kk, we, wa, ra;
      logic [7:0] wd;
      tk = ($urandom % 2) == 0;
      kk = ($urandom % 40) == 0;
      we = ($urandom % 8) == 0;
      wa = ($urandom % 3) == 0;
      ra = $urandom % 2;
      wd = 8'($urandom);
      if (wa && ($urandom % 4 != 0)) wd[7] = 1'b1;
      cyc(tk, kk, we, wa, wd, ra, "R2 random");
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule